// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block decides which NaN a floating-point unit delivers when a two-input single-precision operation has at least one NaN operand. It sorts each operand into quiet NaN, signaling NaN or non-NaN and applies one of several priority rules, chosen at run time, to pick an operand. If the picked operand is signaling, the block makes it quiet. It also raises an invalid-operation flag whenever a signaling NaN is present. A default-NaN mode replaces the picked value with a fixed pattern. A design parameter selects which of two opposite meanings the top fraction bit carries.

The arithmetic datapath calls the block only after it has found a NaN among its inputs. If neither operand is a NaN, the result is meaningless, and a misuse output reports the case. A parameter can place a one-cycle output register, with a valid strobe, after the logic.

Top module: `nan_prop_sel`

## Requirements
- R1: With INV_QUIET=0, an operand whose exponent bits [30:23] are all ones is a quiet NaN when fraction bit 22 is 1. It is a signaling NaN when bit 22 is 0 and bits [21:0] are not all zero. An all-ones exponent with a zero fraction is not a NaN.
- R2: With INV_QUIET=1, the meaning of bit 22 is reversed. An all-ones exponent with bit 22 = 1 is a signaling NaN. An all-ones exponent with bit 22 = 0 and a nonzero [21:0] is a quiet NaN.
- R3: `invalid` is 1 exactly when at least one operand is a signaling NaN. This holds in every style and whether or not `dflt_mode` is set.
- R4: When `dflt_mode`=1, `result` is the default NaN whatever the operands are. With INV_QUIET=1 the default NaN is 0x7FBFFFFF. With INV_QUIET=0 it is 0xFFC00000 when style is 2, and 0x7FC00000 for every other style.
- R5: Style 0, and reserved style 3 which behaves the same, picks the first match in this order: A if signaling, then B if signaling, then A if quiet, then B.
- R6: Style 1 picks A if A is any NaN; otherwise it picks B.
- R7: Style 2 picks a quiet operand over a signaling one. It picks the only NaN when just one operand is a NaN. When both operands are of the same kind, it picks the one with the larger magnitude, where magnitude means bits [30:0] read as an unsigned number.
- R8: In style 2, if the magnitudes are equal, the operand whose full 32-bit value is the smaller unsigned number wins, so a positive operand beats a negative one.
- R9: With INV_QUIET=0, a picked signaling operand leaves the block with bit 22 forced to 1 and every other bit unchanged.
- R10: With INV_QUIET=1, a picked signaling operand is replaced by the default NaN from R4.
- R11: `misuse` is 1 when neither operand is a NaN.
- R12: With REG_OUT=1, the outputs for an input presented with `in_valid`=1 appear after the next rising clock edge, with `out_valid`=1. A synchronous active-low reset clears `out_valid`, `result`, `invalid` and `misuse` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| style | input | 2 | Priority rule: 0 ordered, 1 first NaN, 2 magnitude, 3 same as 0 |
| dflt_mode | input | 1 | Force the default NaN onto the result |
| out_valid | output | 1 | Result outputs are valid |
| result | output | 32 | The NaN to deliver |
| invalid | output | 1 | A signaling NaN was present |
| misuse | output | 1 | Neither operand was a NaN |

## Verification
A wrong operand class shows up at the output in the same transaction. It appears as a wrong `invalid` value, a wrong pick under style 0 or 2, or a signaling pattern on `result` that was not silenced. With the output register it is visible one cycle after the input. A reversed magnitude comparison or tie-break appears only in style 2 with operands of the same kind, so the tests pair operands of equal magnitude and opposite signs in both orders. A stuck default-NaN selection appears only when `dflt_mode` is set, so every style is tested with that mode.

// File: rtl/nan_prop_pkg.sv
// Shared definitions for the NaN result selector.
// Assumes the style code is two bits wide; code 3 is reserved and aliases code 0.
package nan_prop_pkg;
    typedef enum logic [1:0] {
        SEL_ORDERED = 2'd0,
        SEL_FIRST   = 2'd1,
        SEL_MAG     = 2'd2,
        SEL_ALT     = 2'd3
    } nan_style_e;
endpackage

// File: rtl/nan_classify.sv
// Sorts one floating-point word into quiet NaN, signaling NaN or neither.
// Assumes IEEE field order: sign, exponent, fraction (MSB first).
module nan_classify #(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter bit INV_QUIET = 1'b0,
    localparam int W        = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] value,
    output logic         is_quiet,
    output logic         is_sig
);
    logic exp_ones;
    logic top_bit;
    logic low_nz;

    // Split fields and apply the polarity chosen by INV_QUIET.
    always_comb begin
        exp_ones = &value[W-2:FRAC_W];
        top_bit  = value[FRAC_W-1];
        low_nz   = |value[FRAC_W-2:0];
        if (INV_QUIET) begin
            is_sig   = exp_ones & top_bit;
            is_quiet = exp_ones & ~top_bit & low_nz;
        end else begin
            is_quiet = exp_ones & top_bit;
            is_sig   = exp_ones & ~top_bit & low_nz;
        end
    end
endmodule

// File: rtl/nan_pick.sv
// Chooses which operand's NaN to propagate under the selected style.
// Assumes the class flags come from nan_classify; the output means "take B".
module nan_pick
    import nan_prop_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   style,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_q,
    input  logic         a_s,
    input  logic         b_q,
    input  logic         b_s,
    output logic         take_b
);
    logic a_wins_mag;

    // Magnitude comparison without sign, full-value tie-break favouring smaller A.
    always_comb begin
        if (a[W-2:0] != b[W-2:0]) a_wins_mag = a[W-2:0] > b[W-2:0];
        else                      a_wins_mag = a < b;
    end

    // Priority rule per style.
    always_comb begin
        unique case (nan_style_e'(style))
            SEL_FIRST: take_b = ~(a_q | a_s);
            SEL_MAG: begin
                if (a_s)      take_b = b_s ? ~a_wins_mag : b_q;
                else if (a_q) take_b = b_q ? ~a_wins_mag : 1'b0;
                else          take_b = 1'b1;
            end
            default: begin
                if (a_s)      take_b = 1'b0;
                else if (b_s) take_b = 1'b1;
                else          take_b = ~a_q;
            end
        endcase
    end
endmodule

// File: rtl/nan_prop_sel.sv
// Top: classifies both operands, picks a NaN, silences it, applies default mode,
// and optionally registers the outputs. Assumes at least one operand is a NaN;
// flags the other case on misuse.
module nan_prop_sel
    import nan_prop_pkg::*;
#(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter bit INV_QUIET = 1'b0,
    parameter bit REG_OUT   = 1'b1,
    localparam int W        = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   style,
    input  logic         dflt_mode,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         invalid,
    output logic         misuse
);
    localparam logic [W-1:0] QBIT   = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DN_POS = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DN_NEG = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DN_INV = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic [W-1:0] ops [2];
    logic [1:0]   op_q;
    logic [1:0]   op_s;
    logic         take_b;
    logic [W-1:0] chosen;
    logic         chosen_sig;
    logic [W-1:0] dn;
    logic [W-1:0] nxt_res;
    logic         nxt_inv;
    logic         nxt_mis;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One classifier per operand.
    for (genvar i = 0; i < 2; i++) begin : g_cls
        nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INV_QUIET(INV_QUIET)) u_cls (
            .value    (ops[i]),
            .is_quiet (op_q[i]),
            .is_sig   (op_s[i])
        );
    end

    nan_pick #(.W(W)) u_pick (
        .style  (style),
        .a      (op_a),
        .b      (op_b),
        .a_q    (op_q[0]),
        .a_s    (op_s[0]),
        .b_q    (op_q[1]),
        .b_s    (op_s[1]),
        .take_b (take_b)
    );

    // Default NaN pattern for the polarity and style.
    always_comb begin
        if (INV_QUIET)                          dn = DN_INV;
        else if (nan_style_e'(style) == SEL_MAG) dn = DN_NEG;
        else                                    dn = DN_POS;
    end

    // Silence the chosen operand and form the flags.
    always_comb begin
        chosen     = take_b ? op_b : op_a;
        chosen_sig = take_b ? op_s[1] : op_s[0];
        if (dflt_mode)       nxt_res = dn;
        else if (chosen_sig) nxt_res = INV_QUIET ? dn : (chosen | QBIT);
        else                 nxt_res = chosen;
        nxt_inv = |op_s;
        nxt_mis = ~(|op_s | |op_q);
    end

    if (REG_OUT) begin : g_reg
        logic r_q;
        logic r_s;

        // Output register, loaded on in_valid, synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                result    <= '0;
                invalid   <= 1'b0;
                misuse    <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result  <= nxt_res;
                    invalid <= nxt_inv;
                    misuse  <= nxt_mis;
                end
            end
        end

        nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INV_QUIET(INV_QUIET)) u_res_cls (
            .value    (result),
            .is_quiet (r_q),
            .is_sig   (r_s)
        );

        // R12
        valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R3
        invalid_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (op_s != 2'b00)) |=> invalid);
        // R9
        quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !misuse) |-> (r_q && !r_s));
        // R4
        dflt_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && dflt_mode) |=> (&result[W-2:FRAC_W]));
        // R11
        misuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && misuse) |-> !invalid);
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = nxt_res;
        assign invalid   = nxt_inv;
        assign misuse    = nxt_mis;
    end
endmodule

// File: tb/test_nan_prop_sel.sv
module test_nan_prop_sel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic [1:0]  style;
    logic        dflt_mode;
    logic        ov_n, inv_n, mis_n;
    logic [31:0] res_n;
    logic        ov_i, inv_i, mis_i;
    logic [31:0] res_i;
    int          n_run = 0;
    int          n_fail = 0;

    localparam logic [31:0] QA  = 32'h7FC00001;
    localparam logic [31:0] QB  = 32'hFFC00002;
    localparam logic [31:0] SA  = 32'h7F800005;
    localparam logic [31:0] SB  = 32'h7F800009;
    localparam logic [31:0] NUM = 32'h3F800000;
    localparam logic [31:0] INF = 32'h7F800000;

    always #10 clk = ~clk;

    nan_prop_sel #(.INV_QUIET(1'b0)) i_nan_prop_sel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .style(style), .dflt_mode(dflt_mode), .out_valid(ov_n), .result(res_n),
        .invalid(inv_n), .misuse(mis_n));

    nan_prop_sel #(.INV_QUIET(1'b1)) i_nan_prop_sel_inv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .style(style), .dflt_mode(dflt_mode), .out_valid(ov_i), .result(res_i),
        .invalid(inv_i), .misuse(mis_i));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Present one transaction and wait until the registered outputs show it.
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] s, input logic dm);
        @(negedge clk);
        op_a = a; op_b = b; style = s; dflt_mode = dm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; style = 2'd0; dflt_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 reset out_valid", 32'(ov_n), 32'd0);
        check("R12 reset result", res_n, 32'd0);
        check("R12 reset invalid", 32'(inv_n), 32'd0);
        check("R12 reset misuse", 32'(mis_n), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_timing();
        apply(QA, NUM, 2'd1, 1'b0);
        check("R12 out_valid after in_valid", 32'(ov_n), 32'd1);
        @(negedge clk);
        check("R12 out_valid drops", 32'(ov_n), 32'd0);
    endtask

    task automatic t_classify();
        apply(32'h7FC00000, NUM, 2'd1, 1'b0);
        check("R1 quiet with zero low bits", res_n, 32'h7FC00000);
        check("R1 quiet raises nothing", 32'(inv_n), 32'd0);
        apply(32'h7F800001, NUM, 2'd1, 1'b0);
        check("R1 signaling flag", 32'(inv_n), 32'd1);
        check("R9 silenced", res_n, 32'h7FC00001);
        apply(32'h7F800001, NUM, 2'd1, 1'b0);
        check("R2 inverted quiet passes", res_i, 32'h7F800001);
        check("R2 inverted quiet no flag", 32'(inv_i), 32'd0);
    endtask

    task automatic t_ordered();
        apply(QA, SB, 2'd0, 1'b0);
        check("R5 B signaling wins", res_n, 32'h7FC00009);
        check("R3 flag", 32'(inv_n), 32'd1);
        apply(SA, SB, 2'd0, 1'b0);
        check("R5 A signaling first", res_n, 32'h7FC00005);
        apply(QA, QB, 2'd0, 1'b0);
        check("R5 A quiet first", res_n, QA);
        apply(NUM, QB, 2'd0, 1'b0);
        check("R5 B quiet last", res_n, QB);
        apply(QA, SB, 2'd3, 1'b0);
        check("R5 code 3 alias", res_n, 32'h7FC00009);
    endtask

    task automatic t_first();
        apply(QA, SB, 2'd1, 1'b0);
        check("R6 A any NaN", res_n, QA);
        check("R3 flag from B", 32'(inv_n), 32'd1);
        apply(NUM, SB, 2'd1, 1'b0);
        check("R6 B when A number", res_n, 32'h7FC00009);
        apply(SA, QB, 2'd1, 1'b0);
        check("R6 A signaling silenced", res_n, 32'h7FC00005);
    endtask

    task automatic t_magnitude();
        apply(SA, QB, 2'd2, 1'b0);
        check("R7 quiet beats signaling B", res_n, QB);
        apply(QA, SB, 2'd2, 1'b0);
        check("R7 quiet beats signaling A", res_n, QA);
        apply(SA, SB, 2'd2, 1'b0);
        check("R7 larger signaling", res_n, 32'h7FC00009);
        apply(QA, QB, 2'd2, 1'b0);
        check("R7 larger quiet", res_n, QB);
        apply(INF, SA, 2'd2, 1'b0);
        check("R7 only NaN", res_n, 32'h7FC00005);
        apply(32'hFFC00003, 32'h7FC00003, 2'd2, 1'b0);
        check("R8 tie positive B", res_n, 32'h7FC00003);
        apply(32'h7FC00003, 32'hFFC00003, 2'd2, 1'b0);
        check("R8 tie positive A", res_n, 32'h7FC00003);
    endtask

    task automatic t_default();
        apply(SA, QB, 2'd0, 1'b1);
        check("R4 style 0 default", res_n, 32'h7FC00000);
        check("R3 flag in default mode", 32'(inv_n), 32'd1);
        apply(QA, QB, 2'd2, 1'b1);
        check("R4 style 2 default", res_n, 32'hFFC00000);
        check("R4 inverted default", res_i, 32'h7FBFFFFF);
        apply(QA, QB, 2'd1, 1'b1);
        check("R4 style 1 default", res_n, 32'h7FC00000);
        check("R3 no flag", 32'(inv_n), 32'd0);
    endtask

    task automatic t_inverted_silence();
        apply(32'h7FC00000, 32'h7F800001, 2'd0, 1'b0);
        check("R10 signaling replaced", res_i, 32'h7FBFFFFF);
        check("R2 inverted signaling flag", 32'(inv_i), 32'd1);
    endtask

    task automatic t_misuse();
        apply(NUM, INF, 2'd0, 1'b0);
        check("R11 misuse set", 32'(mis_n), 32'd1);
        apply(QA, NUM, 2'd0, 1'b0);
        check("R11 misuse clear", 32'(mis_n), 32'd0);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_timing();
        t_classify();
        t_ordered();
        t_first();
        t_magnitude();
        t_default();
        t_inverted_silence();
        t_misuse();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule